// File: doc/BRIEF.md
# Rewindable Single-Clock FIFO

This block is a synchronous first-in first-out buffer for 36-bit words with a configurable power-of-two depth. It has three clean-up actions, each started by an active-low input: a master reset that clears everything and reloads the configuration, a partial reset that empties the buffer but keeps the configuration, and a rewind that lets the reader replay what has been written since the last reset. The partial reset and the rewind share one input. A select pin picks which of the two that input performs. A reset or rewind takes effect only when its input has stayed low for a programmable number of clock edges. This rejects glitches on slow control lines.

Two thresholds, loaded at master reset, drive active-low near-empty and near-full indications. On the first clock after a master reset ends, a configuration input chooses how reads behave. In registered-read mode the reader requests each word explicitly and gets it on the next clock. In fall-through mode the head word already sits on the output whenever the output-ready flag is high, and a read request only removes it. After any reset, the input-ready flag waits a fixed number of clocks before it lets writes in.

Top module: `rwind_fifo`

## Requirements
- R1: A master reset or a shared-pin action takes effect only after its input has been sampled low on 4 consecutive rising edges. A shorter low pulse leaves the stored words and all flags unchanged.
- R2: Once a master or partial reset takes effect, the state is in_rdy low, out_rdy low, almost_empty_n low (asserted) and almost_full_n high (deasserted). Both pointers return to location 0, so the first word written afterwards is the first word read.
- R3: After the last edge on which a reset acts, in_rdy stays low on the first following rising edge and goes high on the second. Writes are refused until then.
- R4: A partial reset keeps the thresholds and the read mode in force before it. It also clears the registered-read output to zero.
- R5: The read mode is sampled from cfg_std on the first rising edge after a master reset stops acting. A value of 1 selects registered-read mode and 0 selects fall-through mode.
- R6: In registered-read mode, rd_en while out_rdy is high loads the head word onto rd_data on that clock edge. Otherwise rd_data holds its value. out_rdy is high whenever at least one word is stored.
- R7: In fall-through mode, rd_data shows the head word whenever out_rdy is high, with no read request. rd_en while out_rdy is high removes that word.
- R8: With rt_sel high, a qualified low on pr_rt_n moves only the read pointer back to location 0. The words written since the last reset are then read again in order, in_rdy is unaffected, and later writes append after them.
- R9: With rt_sel low, a qualified low on pr_rt_n performs a partial reset.
- R10: almost_empty_n is low when the number of stored words is at most the empty threshold. almost_full_n is low when the free space is at most the full threshold.
- R11: The buffer holds at most DEPTH words. A write while in_rdy is low and a read while out_rdy is low are ignored and move no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| mrst_n | input | 1 | Master reset, active low, qualified by hold time |
| pr_rt_n | input | 1 | Shared active-low partial reset / rewind input |
| rt_sel | input | 1 | 1: pr_rt_n rewinds; 0: pr_rt_n partially resets |
| cfg_std | input | 1 | Read mode sampled after master reset: 1 registered, 0 fall-through |
| ae_ofs | input | AW+1 | Near-empty threshold, loaded at master reset |
| af_ofs | input | AW+1 | Near-full threshold, loaded at master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WORD_W | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | WORD_W | Read word |
| in_rdy | output | 1 | High when a write will be accepted |
| out_rdy | output | 1 | High when at least one word is stored |
| almost_empty_n | output | 1 | Low when occupancy is at or below the empty threshold |
| almost_full_n | output | 1 | Low when free space is at or below the full threshold |

## Verification
The assertions take master reset low as their only disable. They assume the bench opens with mrst_n held low long enough for a full master reset, so every register has a defined value before any property is evaluated. The rewind property also assumes no more than DEPTH words are written between a reset and a rewind. The stimulus respects this: it starts with mrst_n low, changes inputs only on falling edges, and writes at most three words before each rewind. It also keeps cfg_std steady through the mode-sampling edge and changes it only after that edge.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
   localparam int unsigned RWF_WORD_W = 36;

   typedef enum logic {
      TM_FWFT = 1'b0,
      TM_STD  = 1'b1
   } tmode_e;
endpackage

// File: rtl/rwf_rst_filt.sv
// Qualifies an active-low control input: hit is high once the input has
// been seen low on HOLD_EDGES consecutive rising edges, and stays high
// until the first edge that sees it high again.
module rwf_rst_filt #(
   parameter int unsigned HOLD_EDGES = 4
) (
   input  logic clk,
   input  logic pin_n,
   output logic hit
);
   localparam int unsigned CW = $clog2(HOLD_EDGES + 1);
   localparam logic [CW-1:0] TOP = CW'(HOLD_EDGES);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (pin_n)
         run_q <= '0;
      else if (run_q != TOP)
         run_q <= run_q + 1'b1;
   end

   assign hit = (run_q == TOP);
endmodule

// File: rtl/rwf_ram.sv
// Word storage: one synchronous write port, one combinational read port.
module rwf_ram #(
   parameter int unsigned WORD_W = 36,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/rwf_level.sv
// Occupancy and threshold flags from the wrap-extended pointers.
module rwf_level #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
   input  logic [PW-1:0] wr_ptr,
   input  logic [PW-1:0] rd_ptr,
   input  logic [PW-1:0] ae_lim,
   input  logic [PW-1:0] af_lim,
   output logic [PW-1:0] fill,
   output logic          is_full,
   output logic          is_empty,
   output logic          ae_n,
   output logic          af_n
);
   localparam logic [PW-1:0] CAP = PW'(DEPTH);

   logic [PW-1:0] room;

   assign fill     = wr_ptr - rd_ptr;
   assign room     = CAP - fill;
   assign is_full  = (fill == CAP);
   assign is_empty = (fill == '0);
   assign ae_n     = !(fill <= ae_lim);
   assign af_n     = !(room <= af_lim);
endmodule

// File: rtl/rwind_fifo.sv
module rwind_fifo
   import rwf_pkg::*;
#(
   parameter int unsigned WORD_W     = RWF_WORD_W,
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned HOLD_EDGES = 4,
   parameter int unsigned READY_DLY  = 2,
   localparam int unsigned AW        = $clog2(DEPTH),
   localparam int unsigned PW        = AW + 1
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              pr_rt_n,
   input  logic              rt_sel,
   input  logic              cfg_std,
   input  logic [PW-1:0]     ae_ofs,
   input  logic [PW-1:0]     af_ofs,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic              in_rdy,
   output logic              out_rdy,
   output logic              almost_empty_n,
   output logic              almost_full_n
);
   localparam int unsigned WKW = $clog2(READY_DLY + 1);
   localparam logic [WKW-1:0] WAKE_DONE = WKW'(READY_DLY);

   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rwind_fifo: DEPTH must be a power of two of at least 2");
   end
   if (HOLD_EDGES < 1) begin : g_bad_hold
      $error("rwind_fifo: HOLD_EDGES must be at least 1");
   end
   if (READY_DLY < 1) begin : g_bad_dly
      $error("rwind_fifo: READY_DLY must be at least 1");
   end

   // qualified control inputs: index 0 master, index 1 shared
   logic [1:0] pins_n;
   logic [1:0] hits;
   assign pins_n = {pr_rt_n, mrst_n};

   for (genvar g = 0; g < 2; g++) begin : g_filt
      rwf_rst_filt #(.HOLD_EDGES(HOLD_EDGES)) u_filt (
         .clk   (clk),
         .pin_n (pins_n[g]),
         .hit   (hits[g])
      );
   end

   logic mr_hit, pr_hit, rt_hit, rst_hit;
   assign mr_hit  = hits[0];
   assign pr_hit  = hits[1] && !rt_sel && !mr_hit;
   assign rt_hit  = hits[1] &&  rt_sel && !mr_hit;
   assign rst_hit = mr_hit || pr_hit;

   // state
   logic [PW-1:0]     wr_ptr, rd_ptr;
   logic [PW-1:0]     ae_lim, af_lim;
   logic [WKW-1:0]    wake;
   logic              mode_arm;
   tmode_e            std_mode_q;
   logic [WORD_W-1:0] rd_q;

   logic [PW-1:0]     fill;
   logic              is_full, is_empty;
   logic [WORD_W-1:0] head;

   rwf_level #(.DEPTH(DEPTH)) u_level (
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .ae_lim   (ae_lim),
      .af_lim   (af_lim),
      .fill     (fill),
      .is_full  (is_full),
      .is_empty (is_empty),
      .ae_n     (almost_empty_n),
      .af_n     (almost_full_n)
   );

   logic wr_fire, rd_fire, busy;
   assign busy    = rst_hit || rt_hit;
   assign in_rdy  = (wake == WAKE_DONE) && !is_full;
   assign out_rdy = !is_empty;
   assign wr_fire = wr_en && in_rdy && !busy;
   assign rd_fire = rd_en && out_rdy && !busy;

   rwf_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .we    (wr_fire),
      .waddr (wr_ptr[AW-1:0]),
      .wdata (wr_data),
      .raddr (rd_ptr[AW-1:0]),
      .rdata (head)
   );

   // pointers, wake-up delay and registered read word
   always_ff @(posedge clk) begin
      if (rst_hit) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         wake   <= '0;
         rd_q   <= '0;
      end else begin
         if (wake != WAKE_DONE)
            wake <= wake + 1'b1;
         if (rt_hit) begin
            rd_ptr <= '0;
         end else begin
            if (wr_fire)
               wr_ptr <= wr_ptr + 1'b1;
            if (rd_fire) begin
               rd_ptr <= rd_ptr + 1'b1;
               if (std_mode_q == TM_STD)
                  rd_q <= head;
            end
         end
      end
   end

   // configuration: thresholds on master reset, mode on the edge after
   always_ff @(posedge clk) begin
      if (mr_hit) begin
         ae_lim   <= ae_ofs;
         af_lim   <= af_ofs;
         mode_arm <= 1'b1;
      end else if (mode_arm) begin
         std_mode_q <= tmode_e'(cfg_std);
         mode_arm   <= 1'b0;
      end
   end

   assign rd_data = (std_mode_q == TM_STD) ? rd_q : head;

   // ---------------------------------------------------------------
   // assertions
   // ---------------------------------------------------------------
   p_hit_after_low_r1: assert property (@(posedge clk) disable iff (!mrst_n)
      hits[1] |-> $past(!pr_rt_n))
      else $error("R1: shared action without a qualified low input");

   p_flags_reset_r2: assert property (@(posedge clk) disable iff (!mrst_n)
      rst_hit |=> (!in_rdy && !out_rdy && !almost_empty_n && almost_full_n))
      else $error("R2: flags not in reset state after reset");

   p_rdy_late_r3: assert property (@(posedge clk) disable iff (!mrst_n)
      rst_hit ##1 !rst_hit |=> !in_rdy)
      else $error("R3: input ready released too early");

   p_pr_keeps_cfg_r4: assert property (@(posedge clk) disable iff (!mrst_n)
      pr_hit |=> ($stable(ae_lim) && $stable(af_lim) && $stable(std_mode_q)))
      else $error("R4: partial reset altered configuration");

   p_std_hold_r6: assert property (@(posedge clk) disable iff (!mrst_n)
      (std_mode_q == TM_STD && !rd_fire && !rst_hit && !mode_arm) |=> $stable(rd_data))
      else $error("R6: registered read word changed without a read");

   p_fwft_head_r7: assert property (@(posedge clk) disable iff (!mrst_n)
      (std_mode_q == TM_FWFT && out_rdy && !rd_fire && !busy && !mode_arm)
         |=> (out_rdy && $stable(rd_data)))
      else $error("R7: fall-through head word lost without a read");

   p_rt_write_side_r8: assert property (@(posedge clk) disable iff (!mrst_n)
      rt_hit |=> ($stable(wr_ptr) && rd_ptr == '0))
      else $error("R8: rewind disturbed the write side");

   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!mrst_n)
      fill <= PW'(DEPTH))
      else $error("R11: occupancy beyond capacity");

   p_no_underflow_r11: assert property (@(posedge clk) disable iff (!mrst_n)
      (rd_en && !out_rdy && !busy) |=> $stable(rd_ptr))
      else $error("R11: read pointer moved on an empty read");
endmodule

// File: tb/rwind_fifo_bench.sv
module rwind_fifo_bench;
   localparam int CLK_P = 10;
   localparam int DW    = 36;
   localparam int DEP   = 16;
   localparam int OW    = $clog2(DEP) + 1;

   logic          clk = 1'b0;
   logic          mrst_n = 1'b0, pr_rt_n = 1'b1, rt_sel = 1'b0, cfg_std = 1'b1;
   logic [OW-1:0] ae_ofs = '0, af_ofs = '0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          in_rdy, out_rdy, almost_empty_n, almost_full_n;

   int n_chk = 0, n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   rwind_fifo #(.DEPTH(DEP)) u_rwind_fifo (
      .clk(clk), .mrst_n(mrst_n), .pr_rt_n(pr_rt_n), .rt_sel(rt_sel),
      .cfg_std(cfg_std), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .in_rdy(in_rdy), .out_rdy(out_rdy),
      .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // all tasks start and end on a falling edge
   task automatic push(input logic [DW-1:0] d);
      wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pop_std(input logic [DW-1:0] exp, input string req);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk(req, rd_data, exp);
   endtask

   task automatic pop_fwft(input logic [DW-1:0] exp, input string req);
      chk(req, rd_data, exp);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic mreset(input logic [OW-1:0] ae, input logic [OW-1:0] af, input logic std);
      @(negedge clk);
      mrst_n = 1'b0; ae_ofs = ae; af_ofs = af; cfg_std = std;
      repeat (5) @(negedge clk);
      mrst_n = 1'b1;
      @(negedge clk);
      chk("R2 in_rdy", in_rdy, 0);
      chk("R2 out_rdy", out_rdy, 0);
      chk("R2 almost_empty_n", almost_empty_n, 0);
      chk("R2 almost_full_n", almost_full_n, 1);
      @(negedge clk);
      chk("R3 in_rdy first edge", in_rdy, 0);
      cfg_std = ~std;
      @(negedge clk);
      chk("R3 in_rdy second edge", in_rdy, 1);
   endtask

   task automatic shared(input logic rt, input int hold);
      pr_rt_n = 1'b0; rt_sel = rt;
      repeat (hold) @(negedge clk);
      pr_rt_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_std_order();
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R11 empty read rd_data", rd_data, 0);
      chk("R11 empty read out_rdy", out_rdy, 0);
      for (int i = 0; i < 5; i++) push(DW'(36'h100 + i));
      chk("R6 out_rdy", out_rdy, 1);
      chk("R6 no early data", rd_data, 0);
      for (int i = 0; i < 5; i++) pop_std(DW'(36'h100 + i), "R6 order");
      chk("R6 out_rdy drained", out_rdy, 0);
   endtask

   task automatic t_full();
      for (int k = 1; k <= DEP; k++) begin
         push(DW'(36'hA00000000 + k));
         chk("R10 almost_empty_n", almost_empty_n, (k <= 2) ? 0 : 1);
         chk("R10 almost_full_n", almost_full_n, ((DEP - k) <= 3) ? 0 : 1);
         chk("R11 in_rdy", in_rdy, (k < DEP) ? 1 : 0);
      end
      push(36'hDEAD);
      for (int k = 1; k <= DEP; k++) pop_std(DW'(36'hA00000000 + k), "R11 full contents");
      chk("R11 drained", out_rdy, 0);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R11 read when empty", rd_data, DW'(36'hA00000000 + DEP));
   endtask

   task automatic t_short();
      push(36'h11); push(36'h22); push(36'h33);
      mrst_n = 1'b0;
      repeat (3) @(negedge clk);
      mrst_n = 1'b1;
      @(negedge clk);
      chk("R1 short master out_rdy", out_rdy, 1);
      chk("R1 short master in_rdy", in_rdy, 1);
      shared(1'b0, 3);
      chk("R1 short shared out_rdy", out_rdy, 1);
      pop_std(36'h11, "R1 data kept");
      pop_std(36'h22, "R1 data kept");
      pop_std(36'h33, "R1 data kept");
   endtask

   task automatic t_partial();
      push(36'h44); push(36'h55); push(36'h66);
      ae_ofs = '0; af_ofs = '0; cfg_std = 1'b0;
      pr_rt_n = 1'b0; rt_sel = 1'b0;
      repeat (5) @(negedge clk);
      pr_rt_n = 1'b1;
      @(negedge clk);
      chk("R9 out_rdy", out_rdy, 0);
      chk("R9 in_rdy", in_rdy, 0);
      chk("R9 almost_empty_n", almost_empty_n, 0);
      chk("R9 almost_full_n", almost_full_n, 1);
      @(negedge clk);
      chk("R3 partial first edge", in_rdy, 0);
      @(negedge clk);
      chk("R3 partial second edge", in_rdy, 1);
      push(36'h77); push(36'h88);
      chk("R4 old empty threshold", almost_empty_n, 0);
      push(36'h99);
      chk("R4 threshold crossed", almost_empty_n, 1);
      chk("R4 registered mode kept", rd_data, 0);
      pop_std(36'h77, "R2 pointer at start");
      pop_std(36'h88, "R4 order");
      pop_std(36'h99, "R4 order");
   endtask

   task automatic t_retransmit();
      mreset(5'd2, 5'd3, 1'b1);
      push(36'h10); push(36'h20); push(36'h30);
      pop_std(36'h10, "R8 first pass");
      pop_std(36'h20, "R8 first pass");
      shared(1'b1, 5);
      chk("R8 in_rdy kept", in_rdy, 1);
      chk("R8 out_rdy", out_rdy, 1);
      pop_std(36'h10, "R8 replay");
      pop_std(36'h20, "R8 replay");
      pop_std(36'h30, "R8 replay");
      chk("R8 replay drained", out_rdy, 0);
      push(36'h40);
      pop_std(36'h40, "R8 append after rewind");
   endtask

   task automatic t_fwft();
      mreset(5'd2, 5'd3, 1'b0);
      push(36'hAB);
      chk("R7 out_rdy without read", out_rdy, 1);
      chk("R5 fall-through head", rd_data, 36'hAB);
      push(36'hCD);
      chk("R7 head held", rd_data, 36'hAB);
      pop_fwft(36'hAB, "R7 head");
      pop_fwft(36'hCD, "R7 next head");
      chk("R7 drained", out_rdy, 0);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      mreset(5'd2, 5'd3, 1'b1);
      t_std_order();
      t_full();
      t_short();
      t_partial();
      t_retransmit();
      t_fwft();
      summary();
   end
endmodule